// File: doc/BRIEF.md
# SD Block Stream Adapter

This adapter sits between the block buffer side of a DMA-capable SD/eMMC card controller and a pair of streaming ports. When a command starts, the DMA target address chooses the data path. A target of all ones sends card data to the outgoing stream or takes it from the incoming stream. Any other value hands the transfer to an external memory-mapped DMA engine, which appears here only as a request that is held until a completion strobe arrives. The command's direction bit, not the address, decides whether the card is read (data flows out on the outgoing stream) or written (data is taken from the incoming stream).

Data moves in 32-bit words, so a 512-byte block is 128 beats. A beat counter wraps at every block and a block counter, loaded from the command, ends the transfer after the last block. On reads every block ends with a last-beat marker. On writes the incoming stream has no marker, so block edges come only from the beat count. The incoming words fill a one-block buffer, and that buffer is offered to the card side only once it is full. A transfer error aborts the transfer, drops any partial block and sets a sticky error flag. A synchronous soft reset returns everything to idle and empty.

State machine: `ST_IDLE`, `ST_RD_RUN` (card words moving to the outgoing stream), `ST_RD_TAIL` (last word waiting for acceptance), `ST_WR_FILL` (incoming stream filling the buffer), `ST_WR_DRAIN` (full buffer moving to the card), `ST_MEM_WAIT` (memory DMA owns the transfer). The transitions are:
- IDLE→RD_RUN, WR_FILL or MEM_WAIT on an accepted start.
- RD_RUN→RD_TAIL when the final beat of the final block is loaded.
- RD_TAIL→IDLE when that beat is taken.
- WR_FILL→WR_DRAIN on the 128th accepted word.
- WR_DRAIN→WR_FILL when a block is done and more blocks remain.
- WR_DRAIN→IDLE when the last block is done.
- MEM_WAIT→IDLE on completion.
- Any state→IDLE on error or soft reset.

Top module: `sd_blk_stream_adapter`

## Requirements
- R1: A start with `dma_addr` all ones selects stream mode. Any other address selects memory mode, in which `mem_req` is high and `m_tvalid`, `s_tready` and `card_rd_ready` all stay low.
- R2: In stream mode, `cmd_write`=0 moves card words to the outgoing stream and `cmd_write`=1 moves incoming stream words to the card.
- R3: On reads, `m_tlast` is 1 exactly on the beat with index 127 within each block (beats counted from 0 per block), including every block of a multi-block read.
- R4: Once `m_tvalid` is high, it and `m_tdata` hold until `m_tready` is seen. Outgoing words equal the card words in order, with none dropped or repeated.
- R5: On writes, the block edge is found by counting 128 words with no marker. `s_tready` is low while the buffer holds a full block. `card_wr_valid` rises only after all 128 words of the block have been taken, and the card receives them in order.
- R6: The block counter loads `cmd_nblk` at start and counts down at each block end. `busy` falls after the last block. A start with `cmd_nblk`=0 is ignored.
- R7: `xfer_err` aborts any transfer to idle, clears the outgoing register, drops a partial block and sets `err_flag`, which stays set until soft reset.
- R8: `soft_reset` returns the block to idle with no valid outgoing word and `err_flag` cleared.
- R9: `cmd_start` while `busy` is ignored.
- R10: In memory mode, `mem_req` holds until `mem_done`. `mem_write` reports the direction of the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_reset | input | 1 | Synchronous return to idle, clears error |
| dma_addr | input | 32 | DMA target address; all ones selects streams |
| cmd_start | input | 1 | Command start strobe |
| cmd_write | input | 1 | 1 = card write, 0 = card read |
| cmd_nblk | input | 16 | Number of blocks in the command |
| xfer_err | input | 1 | Transfer error strobe |
| busy | output | 1 | Transfer in progress |
| err_flag | output | 1 | Sticky error flag |
| card_rd_valid | input | 1 | Card-side read word valid |
| card_rd_data | input | 32 | Card-side read word |
| card_rd_ready | output | 1 | Adapter accepts card read word |
| m_tvalid | output | 1 | Outgoing stream valid |
| m_tdata | output | 32 | Outgoing stream data |
| m_tlast | output | 1 | Outgoing stream last beat of block |
| m_tready | input | 1 | Outgoing stream ready |
| s_tvalid | input | 1 | Incoming stream valid |
| s_tdata | input | 32 | Incoming stream data |
| s_tready | output | 1 | Incoming stream ready |
| card_wr_valid | output | 1 | Card-side write word valid |
| card_wr_data | output | 32 | Card-side write word |
| card_wr_ready | input | 1 | Card accepts write word |
| mem_req | output | 1 | Memory DMA engine owns the transfer |
| mem_write | output | 1 | Direction of the memory DMA transfer |
| mem_done | input | 1 | Memory DMA transfer complete |

## Verification
The assertions check on every cycle that:
- a stalled outgoing word holds its value and marker;
- draining to the card starts only on the cycle after a fill beat is accepted;
- memory mode leaves every stream handshake low;
- an error or soft reset lands in idle with the right flag state.

Only the bench scenarios can show the end-to-end properties: the data order across several blocks, the marker on beat 127 of every block, the count of blocks, and that a dropped partial block does not leak into the next write.

// File: rtl/sdsa_pkg.sv
package sdsa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_RUN   = 3'd1,
        ST_RD_TAIL  = 3'd2,
        ST_WR_FILL  = 3'd3,
        ST_WR_DRAIN = 3'd4,
        ST_MEM_WAIT = 3'd5
    } sdsa_state_e;
endpackage

// File: rtl/sdsa_beat_ctr.sv
module sdsa_beat_ctr #(
    parameter int BEATS = 128,
    localparam int W = $clog2(BEATS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] idx,
    output logic         at_last
);
    logic [W-1:0] cnt_q;

    assign idx     = cnt_q;
    assign at_last = (cnt_q == W'(BEATS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/sdsa_blk_ctr.sv
module sdsa_blk_ctr #(
    parameter int NBLK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [NBLK_W-1:0] load_val,
    input  logic              dec,
    output logic              at_one
);
    logic [NBLK_W-1:0] left_q;

    assign at_one = (left_q == NBLK_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (clr)
            left_q <= '0;
        else if (load)
            left_q <= load_val;
        else if (dec && left_q != '0)
            left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/sdsa_blk_buf.sv
module sdsa_blk_buf #(
    parameter int DATA_W = 32,
    parameter int BEATS  = 128,
    localparam int AW    = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [BEATS];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sd_blk_stream_adapter.sv
module sd_blk_stream_adapter
    import sdsa_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BLK_BYTES = 512,
    parameter int ADDR_W    = 32,
    parameter int NBLK_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_reset,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [NBLK_W-1:0] cmd_nblk,
    input  logic              xfer_err,
    output logic              busy,
    output logic              err_flag,
    input  logic              card_rd_valid,
    input  logic [DATA_W-1:0] card_rd_data,
    output logic              card_rd_ready,
    output logic              m_tvalid,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    input  logic              m_tready,
    input  logic              s_tvalid,
    input  logic [DATA_W-1:0] s_tdata,
    output logic              s_tready,
    output logic              card_wr_valid,
    output logic [DATA_W-1:0] card_wr_data,
    input  logic              card_wr_ready,
    output logic              mem_req,
    output logic              mem_write,
    input  logic              mem_done
);
    localparam int BEATS  = BLK_BYTES / (DATA_W / 8);
    localparam int BEAT_W = $clog2(BEATS);

    sdsa_state_e state_q, state_d;

    logic              stream_sel, start_ok;
    logic              rd_load, out_fire, in_fire, card_fire;
    logic              beat_inc, beat_clr, beat_last, blk_dec, blk_one;
    logic [BEAT_W-1:0] beat_idx;
    logic              dir_q, err_q;
    logic              ov_valid_q, ov_last_q;
    logic [DATA_W-1:0] ov_data_q;

    assign stream_sel = &dma_addr;
    assign start_ok   = (state_q == ST_IDLE) && cmd_start && (cmd_nblk != '0);
    assign rd_load    = card_rd_valid && card_rd_ready;
    assign out_fire   = ov_valid_q && m_tready;
    assign in_fire    = s_tvalid && s_tready;
    assign card_fire  = card_wr_valid && card_wr_ready;
    assign beat_inc   = rd_load || in_fire || card_fire;
    assign beat_clr   = soft_reset || xfer_err || (state_q == ST_IDLE);
    assign blk_dec    = (rd_load || card_fire) && beat_last;

    sdsa_beat_ctr #(.BEATS(BEATS)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (beat_clr),
        .inc    (beat_inc),
        .idx    (beat_idx),
        .at_last(beat_last)
    );

    sdsa_blk_ctr #(.NBLK_W(NBLK_W)) u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_reset || xfer_err),
        .load    (start_ok),
        .load_val(cmd_nblk),
        .dec     (blk_dec),
        .at_one  (blk_one)
    );

    sdsa_blk_buf #(.DATA_W(DATA_W), .BEATS(BEATS)) u_buf (
        .clk  (clk),
        .we   (in_fire),
        .waddr(beat_idx),
        .wdata(s_tdata),
        .raddr(beat_idx),
        .rdata(card_wr_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (soft_reset)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    if (!stream_sel)
                        state_d = ST_MEM_WAIT;
                    else if (cmd_write)
                        state_d = ST_WR_FILL;
                    else
                        state_d = ST_RD_RUN;
                end
            end
            ST_RD_RUN: begin
                if (rd_load && beat_last && blk_one)
                    state_d = ST_RD_TAIL;
            end
            ST_RD_TAIL: begin
                if (out_fire)
                    state_d = ST_IDLE;
            end
            ST_WR_FILL: begin
                if (in_fire && beat_last)
                    state_d = ST_WR_DRAIN;
            end
            ST_WR_DRAIN: begin
                if (card_fire && beat_last)
                    state_d = blk_one ? ST_IDLE : ST_WR_FILL;
            end
            ST_MEM_WAIT: begin
                if (mem_done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (xfer_err)
            state_d = ST_IDLE;
    end

    // Outputs decoded from state
    always_comb begin
        card_rd_ready = 1'b0;
        s_tready      = 1'b0;
        card_wr_valid = 1'b0;
        mem_req       = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_RD_RUN:   card_rd_ready = !ov_valid_q || m_tready;
            ST_RD_TAIL:  ;
            ST_WR_FILL:  s_tready      = 1'b1;
            ST_WR_DRAIN: card_wr_valid = 1'b1;
            ST_MEM_WAIT: mem_req       = 1'b1;
            default:     ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign err_flag  = err_q;
    assign mem_write = dir_q;
    assign m_tvalid  = ov_valid_q;
    assign m_tdata   = ov_data_q;
    assign m_tlast   = ov_last_q && ov_valid_q;

    // Outgoing stream register, direction and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_valid_q <= 1'b0;
            ov_last_q  <= 1'b0;
            ov_data_q  <= '0;
            dir_q      <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            if (start_ok)
                dir_q <= cmd_write;
            if (soft_reset)
                err_q <= 1'b0;
            else if (xfer_err)
                err_q <= 1'b1;
            if (soft_reset || xfer_err) begin
                ov_valid_q <= 1'b0;
                ov_last_q  <= 1'b0;
            end else if (rd_load) begin
                ov_valid_q <= 1'b1;
                ov_last_q  <= beat_last;
                ov_data_q  <= card_rd_data;
            end else if (out_fire) begin
                ov_valid_q <= 1'b0;
                ov_last_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdsa_checker.sv
module sdsa_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_reset,
    input logic              xfer_err,
    input logic              busy,
    input logic              err_flag,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tlast,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              card_wr_valid,
    input logic              card_rd_ready,
    input logic              mem_req
);
    // R4: a stalled outgoing word keeps its value and marker
    a_r4_hold_stall: assert property (@(posedge clk) disable iff (!rst_n || soft_reset)
        (m_tvalid && !m_tready && !xfer_err) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R5: card drain begins only right after a fill beat was accepted
    a_r5_drain_after_fill: assert property (@(posedge clk) disable iff (!rst_n || soft_reset)
        $rose(card_wr_valid) |-> $past(s_tvalid && s_tready));

    // R1: memory mode leaves every stream handshake idle
    a_r1_mem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!m_tvalid && !s_tready && !card_rd_ready));

    // R7: an error lands in idle with the flag raised
    a_r7_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_err && !soft_reset) |=> (err_flag && !busy && !m_tvalid));

    // R8: soft reset lands in idle, empty, flag clear
    a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> (!busy && !err_flag && !m_tvalid));
endmodule

bind sd_blk_stream_adapter sdsa_checker #(.DATA_W(DATA_W)) u_sdsa_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_reset   (soft_reset),
    .xfer_err     (xfer_err),
    .busy         (busy),
    .err_flag     (err_flag),
    .m_tvalid     (m_tvalid),
    .m_tready     (m_tready),
    .m_tdata      (m_tdata),
    .m_tlast      (m_tlast),
    .s_tvalid     (s_tvalid),
    .s_tready     (s_tready),
    .card_wr_valid(card_wr_valid),
    .card_rd_ready(card_rd_ready),
    .mem_req      (mem_req)
);

// File: tb/tb_sd_blk_stream_adapter.sv
`timescale 1ns/1ps
module tb_sd_blk_stream_adapter;
    localparam int BEATS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_reset = 1'b0;
    logic [31:0] dma_addr = '0;
    logic        cmd_start = 1'b0;
    logic        cmd_write = 1'b0;
    logic [15:0] cmd_nblk = '0;
    logic        xfer_err = 1'b0;
    logic        busy, err_flag;
    logic        card_rd_valid = 1'b0;
    logic [31:0] card_rd_data = '0;
    logic        card_rd_ready;
    logic        m_tvalid, m_tlast;
    logic [31:0] m_tdata;
    logic        m_tready = 1'b0;
    logic        s_tvalid = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tready;
    logic        card_wr_valid;
    logic [31:0] card_wr_data;
    logic        card_wr_ready = 1'b0;
    logic        mem_req, mem_write;
    logic        mem_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sd_blk_stream_adapter dut (
        .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .dma_addr(dma_addr),
        .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_nblk(cmd_nblk),
        .xfer_err(xfer_err), .busy(busy), .err_flag(err_flag),
        .card_rd_valid(card_rd_valid), .card_rd_data(card_rd_data), .card_rd_ready(card_rd_ready),
        .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tready(m_tready),
        .s_tvalid(s_tvalid), .s_tdata(s_tdata), .s_tready(s_tready),
        .card_wr_valid(card_wr_valid), .card_wr_data(card_wr_data), .card_wr_ready(card_wr_ready),
        .mem_req(mem_req), .mem_write(mem_write), .mem_done(mem_done)
    );

    typedef struct packed {
        logic        stream;
        logic        wr;
        logic [3:0]  nblk;
        logic [3:0]  stall;
        logic [15:0] exp_beats;
        logic [3:0]  exp_lasts;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 4'd1, 4'd0, 16'd128, 4'd1},
        '{1'b1, 1'b0, 4'd3, 4'd3, 16'd384, 4'd3},
        '{1'b1, 1'b1, 4'd1, 4'd0, 16'd128, 4'd0},
        '{1'b1, 1'b1, 4'd2, 4'd4, 16'd256, 4'd0},
        '{1'b0, 1'b0, 4'd2, 4'd0, 16'd0,   4'd0},
        '{1'b0, 1'b1, 4'd1, 4'd0, 16'd0,   4'd0}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_cmd(input bit stream, input bit wr, input int nblk);
        @(negedge clk);
        dma_addr  = stream ? 32'hFFFF_FFFF : 32'h0000_4000;
        cmd_write = wr;
        cmd_nblk  = 16'(nblk);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic run_read(input int nblk, input int stall, input int exp_beats,
                            input int exp_lasts, input int base);
        int si = 0, di = 0, derr = 0, lerr = 0, lasts = 0, cyc = 0;
        int total = nblk * BEATS;
        start_cmd(1'b1, 1'b0, nblk);
        check(!mem_req && busy, "R1 stream read selected", mem_req, 0);
        while (di < total && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            card_rd_valid = (si < total);
            card_rd_data  = 32'(base + si);
            m_tready      = (stall == 0) || ((cyc % stall) != 0);
            #1;
            if (card_rd_valid && card_rd_ready) si++;
            if (m_tvalid && m_tready) begin
                if (m_tdata != 32'(base + di)) derr++;
                if (m_tlast) lasts++;
                if (m_tlast != ((di % BEATS) == BEATS - 1)) lerr++;
                di++;
            end
        end
        @(negedge clk);
        card_rd_valid = 1'b0;
        m_tready = 1'b0;
        #1;
        check(derr == 0, "R4 read data order", derr, 0);
        check(lerr == 0, "R3 tlast position", lerr, 0);
        check(lasts == exp_lasts, "R3 tlast count", lasts, exp_lasts);
        check(di == exp_beats, "R2 read beats out", di, exp_beats);
        check(!busy, "R6 idle after last block", busy, 0);
    endtask

    task automatic run_write(input int nblk, input int stall, input int exp_beats, input int base);
        int si = 0, di = 0, derr = 0, early = 0, cyc = 0;
        int total = nblk * BEATS;
        start_cmd(1'b1, 1'b1, nblk);
        check(!mem_req && s_tready, "R2 stream write selected", s_tready, 1);
        while (di < total && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            s_tvalid      = (si < total);
            s_tdata       = 32'(base + si);
            card_wr_ready = (stall == 0) || ((cyc % stall) != 0);
            #1;
            if (card_wr_valid && s_tready) early++;
            if (s_tvalid && s_tready) si++;
            if (card_wr_valid && card_wr_ready) begin
                if (card_wr_data != 32'(base + di)) derr++;
                if (si < ((di / BEATS) + 1) * BEATS) early++;
                di++;
            end
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        card_wr_ready = 1'b0;
        #1;
        check(derr == 0, "R5 write data order", derr, 0);
        check(early == 0, "R5 full block before drain", early, 0);
        check(di == exp_beats, "R5 write beats to card", di, exp_beats);
        check(!busy, "R6 idle after last write block", busy, 0);
    endtask

    task automatic run_mem(input bit wr, input int nblk);
        start_cmd(1'b0, wr, nblk);
        check(mem_req, "R1 memory mode request", mem_req, 1);
        check(!m_tvalid && !s_tready && !card_rd_ready, "R1 streams idle in memory mode",
              {m_tvalid, s_tready, card_rd_ready}, 0);
        check(mem_write == wr, "R10 memory direction", mem_write, wr);
        repeat (5) @(negedge clk);
        check(mem_req, "R10 request held", mem_req, 1);
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
        check(!mem_req && !busy, "R10 done releases", mem_req, 0);
    endtask

    task automatic pulse_soft_reset();
        @(negedge clk);
        soft_reset = 1'b1;
        @(negedge clk);
        soft_reset = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !err_flag && !m_tvalid && !mem_req && !s_tready && !card_wr_valid,
              "R8 reset state", busy, 0);

        for (int v = 0; v < NV; v++) begin
            if (!VECS[v].stream)
                run_mem(VECS[v].wr, int'(VECS[v].nblk));
            else if (VECS[v].wr)
                run_write(int'(VECS[v].nblk), int'(VECS[v].stall), int'(VECS[v].exp_beats),
                          32'h5A00_0000 + v * 4096);
            else
                run_read(int'(VECS[v].nblk), int'(VECS[v].stall), int'(VECS[v].exp_beats),
                         int'(VECS[v].exp_lasts), 32'hA500_0000 + v * 4096);
        end

        // R6: zero block count ignored
        start_cmd(1'b1, 1'b0, 0);
        check(!busy && !card_rd_ready, "R6 zero-block start ignored", busy, 0);

        // R9: start while busy ignored
        start_cmd(1'b0, 1'b0, 1);
        start_cmd(1'b1, 1'b1, 1);
        check(mem_req && !mem_write && !s_tready, "R9 start while busy ignored", mem_write, 0);
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
        check(!busy, "R9 idle after done", busy, 0);

        // R7: error mid read
        start_cmd(1'b1, 1'b0, 2);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            card_rd_valid = 1'b1;
            card_rd_data  = 32'(i);
            m_tready      = (i % 2) == 0;
        end
        @(negedge clk);
        card_rd_valid = 1'b0;
        m_tready = 1'b0;
        xfer_err = 1'b1;
        @(negedge clk);
        xfer_err = 1'b0;
        check(!busy && !m_tvalid && !card_rd_ready, "R7 read aborted", busy, 0);
        check(err_flag, "R7 error flag set", err_flag, 1);
        repeat (3) @(negedge clk);
        check(err_flag, "R7 error flag sticky", err_flag, 1);
        pulse_soft_reset();
        check(!err_flag && !busy, "R8 soft reset clears flag", err_flag, 0);

        // R7: partial write dropped
        start_cmd(1'b1, 1'b1, 1);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tdata  = 32'hDEAD_0000 + 32'(i);
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        xfer_err = 1'b1;
        @(negedge clk);
        xfer_err = 1'b0;
        check(!busy && !card_wr_valid && err_flag, "R7 write aborted", busy, 0);
        pulse_soft_reset();
        run_write(1, 0, 128, 32'h1234_0000);

        // R8: soft reset mid write
        start_cmd(1'b1, 1'b1, 2);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tdata  = 32'(i);
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        soft_reset = 1'b1;
        @(negedge clk);
        soft_reset = 1'b0;
        check(!busy && !s_tready && !card_wr_valid && !err_flag, "R8 soft reset mid write", busy, 0);
        run_read(1, 2, 128, 1, 32'h0BAD_0000);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule